// File: doc/BRIEF.md
# Configurable SPI Word Master

This block is an SPI master that moves one word per transfer. A 16-bit mode word supplies its settings: an operate-enable bit, a bit that floats the serial output while idle, a transfer-length code, the clock idle level, the clock phase and an 8-bit rate divider. The host sets the mode word, presents a transmit word and pulses a start request. The engine lowers its active-low chip select, runs the serial clock for the selected number of bits while shifting data out and sampling data in, then raises chip select and pulses done together with the received word.

Every serial clock half-period lasts a number of system-clock cycles equal to the divider. One extra half-period of chip-select setup comes before the first clock edge, and one of hold comes after the last edge. A start with a setting that cannot run is refused and reported on a one-cycle error strobe. The serial output comes as a data bit plus an enable, so the pad can float the line between transfers.

Top module: `spi_word_master`

## Requirements
- R1: A start request is refused when mode bit 15 (operate enable) is 0, when bits 7:0 (divider) equal 0 or 1, or when bits 13:10 (length code) are 0001 to 0111. A refusal pulses startErr for exactly one cycle, in the cycle after the request, and csN stays high.
- R2: Length code 0000 gives 16 bits. A code 1xxx gives 8 plus xxx bits. The serial clock makes exactly two transitions per bit while csN is low.
- R3: Mode bit 9 sets the serial clock level whenever csN is high (0 idles low, 1 idles high). The clock is back at that level when done pulses.
- R4: With mode bit 8 at 0, the first bit is on dataOut before the first clock edge. serIn is sampled on leading edges and dataOut changes on trailing edges.
- R5: With mode bit 8 at 1, dataOut changes on leading edges and serIn is sampled on trailing edges.
- R6: Each clock half-period lasts D system cycles, where D is bits 7:0. csN stays low for exactly (2N+1)*D cycles for an N-bit transfer. Done pulses in the first cycle with csN high again.
- R7: Bits go out most significant first, taken from the low N bits of txWord. rxWord holds the N received bits right-aligned, with the upper bits zero.
- R8: done is high for exactly one cycle per transfer, and rxWord is valid in that cycle.
- R9: While csN is high, dataOutEn equals the inverse of mode bit 14. While csN is low, dataOutEn is 1.
- R10: A start request that arrives during a transfer is ignored. The transfer in progress completes unchanged and produces a single done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeReg | input | 16 | Mode word (enable, float, length, polarity, phase, divider) |
| startReq | input | 1 | Start pulse |
| txWord | input | 16 | Word to send, right-aligned |
| serIn | input | 1 | Serial data from the slave |
| serClk | output | 1 | Serial clock |
| dataOut | output | 1 | Serial data bit to the slave |
| dataOutEn | output | 1 | Drive enable for dataOut; 0 means the pad floats |
| csN | output | 1 | Active-low chip select |
| rxWord | output | 16 | Received word, right-aligned, zero-extended |
| done | output | 1 | One-cycle completion pulse |
| startErr | output | 1 | One-cycle pulse when a start is refused |

## Verification
The assertions take startReq to be a short pulse. They allow modeReg to change only while csN is high, because the idle clock level and the output float follow the live mode bits. The bench changes the mode word and the slave model only between transfers. It sends one stray start request during a transfer, and checks refusals only from idle. The slave model drives serIn with a defined level at all times, so the sampled data never carries unknowns.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef struct packed {
    logic load;
    logic toggle;
    logic shiftOut;
    logic capture;
    logic finish;
  } spimStrobe_t;

  // transfer length from the 4-bit size code: 0000 -> 16, 1xxx -> 8 + xxx
  function automatic logic [4:0] sizeBits(input logic [3:0] code);
    return (code == 4'd0) ? 5'd16 : {2'b01, code[2:0]};
  endfunction

  function automatic logic modeLegal(input logic [15:0] m);
    return m[15] && (m[7:0] > 8'd1) && ((m[13:10] == 4'd0) || m[13]);
  endfunction

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [15:0]      modeReg,
  input  logic             startReq,
  output logic             busy,
  output logic             startErr,
  output spimStrobe_t      strobe
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int PH_W  = $clog2(2 * WORD_W + 2);

  logic [DIV_W-1:0] halfCnt, divLat;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] nBits;
  logic             phaLat;
  logic             halfEnd, lastHalf, edgeNow, leading, legal;

  assign legal    = modeLegal(modeReg);
  assign halfEnd  = busy && (halfCnt == divLat - DIV_W'(1));
  assign lastHalf = (phase == PH_W'({nBits, 1'b0}));
  assign edgeNow  = halfEnd && !lastHalf;
  assign leading  = !phase[0];

  always_comb begin
    strobe          = '0;
    strobe.load     = !busy && startReq && legal;
    strobe.toggle   = edgeNow;
    strobe.capture  = edgeNow && (leading != phaLat);
    strobe.shiftOut = edgeNow && (leading == phaLat);
    strobe.finish   = halfEnd && lastHalf;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      startErr <= 1'b0;
      halfCnt  <= '0;
      phase    <= '0;
      divLat   <= DIV_W'(2);
      nBits    <= CNT_W'(WORD_W);
      phaLat   <= 1'b0;
    end else begin
      startErr <= 1'b0;
      if (!busy) begin
        if (startReq) begin
          if (legal) begin
            busy    <= 1'b1;
            halfCnt <= '0;
            phase   <= '0;
            divLat  <= modeReg[DIV_W-1:0];
            nBits   <= CNT_W'(sizeBits(modeReg[13:10]));
            phaLat  <= modeReg[8];
          end else begin
            startErr <= 1'b1;
          end
        end
      end else if (halfEnd) begin
        halfCnt <= '0;
        phase   <= phase + PH_W'(1);
        if (lastHalf) busy <= 1'b0;
      end else begin
        halfCnt <= halfCnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic [15:0]       modeReg,
  input  logic [WORD_W-1:0] txWord,
  input  logic              serIn,
  output logic              clkReg,
  output logic              outBit,
  output logic [WORD_W-1:0] rxWord,
  output logic              done
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W:0]   txSh;
  logic [WORD_W-1:0] rxSh, aligned;
  logic [CNT_W-1:0]  nLoad;

  assign nLoad   = CNT_W'(sizeBits(modeReg[13:10]));
  assign aligned = txWord << (CNT_W'(WORD_W) - nLoad);
  assign outBit  = txSh[WORD_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSh   <= '0;
      rxSh   <= '0;
      rxWord <= '0;
      done   <= 1'b0;
      clkReg <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobe.load) begin
        // phase 1 parks the word one place low; the first leading edge lifts the MSB out
        txSh   <= modeReg[8] ? {1'b0, aligned} : {aligned, 1'b0};
        rxSh   <= '0;
        clkReg <= modeReg[9];
      end else begin
        if (strobe.toggle)   clkReg <= !clkReg;
        if (strobe.shiftOut) txSh   <= {txSh[WORD_W-1:0], 1'b0};
        if (strobe.capture)  rxSh   <= {rxSh[WORD_W-2:0], serIn};
        if (strobe.finish) begin
          rxWord <= rxSh;
          done   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spim_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       modeReg,
  input  logic              startReq,
  input  logic [WORD_W-1:0] txWord,
  input  logic              serIn,
  output logic              serClk,
  output logic              dataOut,
  output logic              dataOutEn,
  output logic              csN,
  output logic [WORD_W-1:0] rxWord,
  output logic              done,
  output logic              startErr
);
  spimStrobe_t strobe;
  logic        busy, clkReg;

  spim_ctrl #(.WORD_W(WORD_W), .DIV_W(DIV_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .modeReg(modeReg), .startReq(startReq),
    .busy(busy), .startErr(startErr), .strobe(strobe)
  );

  spim_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modeReg(modeReg),
    .txWord(txWord), .serIn(serIn), .clkReg(clkReg), .outBit(dataOut),
    .rxWord(rxWord), .done(done)
  );

  assign csN       = !busy;
  assign serClk    = busy ? clkReg : modeReg[9];
  assign dataOutEn = busy || !modeReg[14];
endmodule

// File: rtl/spim_chk.sv
module spim_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] modeReg,
  input logic        csN,
  input logic        serClk,
  input logic        dataOutEn,
  input logic        done,
  input logic        startErr
);
  AST_ERR_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    startErr |-> csN); // R1
  AST_IDLE_POLARITY: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (serClk == modeReg[9])); // R3
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(!csN))); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DRIVE_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> dataOutEn); // R9
  AST_FLOAT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (csN && modeReg[14]) |-> !dataOutEn); // R9
endmodule

bind spi_word_master spim_chk chk_i (
  .clk(clk), .rstN(rstN), .modeReg(modeReg), .csN(csN), .serClk(serClk),
  .dataOutEn(dataOutEn), .done(done), .startErr(startErr)
);

// File: tb/spi_word_master_tb.sv
module spi_word_master_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] modeReg = 16'h0000;
  logic        startReq = 1'b0;
  logic [15:0] txWord = 16'h0000;
  logic        serIn = 1'b0;
  logic        serClk, dataOut, dataOutEn, csN, done, startErr;
  logic [15:0] rxWord;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // slave model state
  logic        curCpol = 1'b0, curCpha = 1'b0;
  logic [15:0] slaveData = 16'h0, slaveGot = 16'h0;
  int          slaveIdx = 0;
  int          curBits = 16;
  int          csCycles = 0, toggles = 0;

  // scoreboard queues
  logic [15:0] qRx[$], qSlave[$];
  int          qCs[$], qBits[$];
  logic        qCpol[$];
  logic        prevDone = 1'b0;

  always #4 clk = ~clk;

  spi_word_master dut_i (
    .clk(clk), .rstN(rstN), .modeReg(modeReg), .startReq(startReq),
    .txWord(txWord), .serIn(serIn), .serClk(serClk), .dataOut(dataOut),
    .dataOutEn(dataOutEn), .csN(csN), .rxWord(rxWord), .done(done),
    .startErr(startErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int bitsOf(input logic [15:0] m);
    return (m[13:10] == 4'd0) ? 16 : 8 + int'(m[12:10]);
  endfunction

  function automatic logic [15:0] maskOf(input int n);
    return (n >= 16) ? 16'hFFFF : ((16'h1 << n) - 16'h1);
  endfunction

  // slave: follows the phase rules independently of the design
  always @(negedge csN) begin
    slaveGot = 16'h0;
    slaveIdx = curBits - 1;
    toggles  = 0;
    csCycles = 0;
    if (!curCpha) serIn = slaveData[slaveIdx];
  end

  always @(serClk) begin
    if (csN === 1'b0) begin
      automatic bit lead = (serClk !== curCpol);
      toggles++;
      if (lead != curCpha) begin
        slaveGot = {slaveGot[14:0], dataOut};
      end else if (!curCpha) begin
        slaveIdx--;
        if (slaveIdx >= 0) serIn = slaveData[slaveIdx];
      end else begin
        if (slaveIdx >= 0) serIn = slaveData[slaveIdx];
        slaveIdx--;
      end
    end
  end

  always @(posedge clk) if (csN === 1'b0) csCycles++;

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone && done) chk(0, "R8 done wider than one cycle", 1, 0);
      if (done) begin
        if (qRx.size() == 0) begin
          chk(0, "R10 unexpected done", 1, 0);
        end else begin
          automatic logic [15:0] eRx = qRx.pop_front();
          automatic logic [15:0] eSl = qSlave.pop_front();
          automatic int eCs = qCs.pop_front();
          automatic int eB = qBits.pop_front();
          automatic logic eP = qCpol.pop_front();
          chk(rxWord == eRx, "R7/R4/R5 rxWord", rxWord, eRx);
          chk((slaveGot & maskOf(eB)) == eSl, "R7 slave received", slaveGot, eSl);
          chk(csCycles == eCs, "R6 csN low cycles", csCycles, eCs);
          chk(toggles == 2 * eB, "R2 clock transitions", toggles, 2 * eB);
          chk(serClk == eP, "R3 idle clock after done", serClk, eP);
          chk(csN == 1'b1, "R6 csN high at done", csN, 1);
        end
      end
      prevDone = done;
    end
  end

  task automatic doXfer(input logic [15:0] m, input logic [15:0] tx,
                        input logic [15:0] sd, input bit stray);
    int n = bitsOf(m);
    @(negedge clk);
    modeReg   = m;
    txWord    = tx;
    curCpol   = m[9];
    curCpha   = m[8];
    curBits   = n;
    slaveData = sd;
    qRx.push_back(sd & maskOf(n));
    qSlave.push_back(tx & maskOf(n));
    qCs.push_back((2 * n + 1) * int'(m[7:0]));
    qBits.push_back(n);
    qCpol.push_back(m[9]);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    @(negedge clk);
    chk(csN == 1'b0, "R6 csN low after start", csN, 0);
    chk(dataOutEn == 1'b1, "R9 output driven in transfer", dataOutEn, 1);
    if (stray) begin
      txWord = ~tx;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(qRx.size() == 0, "R10 all transfers completed once", qRx.size(), 0);
  endtask

  task automatic tryBad(input logic [15:0] m, input string why);
    @(negedge clk);
    modeReg  = m;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(startErr == 1'b1, {"R1 error strobe ", why}, startErr, 1);
    chk(csN == 1'b1, {"R1 no transfer ", why}, csN, 1);
    @(negedge clk);
    chk(startErr == 1'b0, {"R1 error one cycle ", why}, startErr, 0);
    repeat (6) @(negedge clk);
    chk(csN == 1'b1 && done == 1'b0, {"R1 still idle ", why}, csN, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == 1'b1, "reset csN", csN, 1);
    chk(done == 1'b0 && startErr == 1'b0, "reset strobes", done, 0);
    chk(serClk == 1'b0, "R3 reset idle clock", serClk, 0);
    chk(dataOutEn == 1'b1, "R9 driven idle with float bit 0", dataOutEn, 1);

    // 16 bits, polarity 0, phase 0, divider 2
    doXfer(16'h8002, 16'hA5C3, 16'h3C96, 0);
    // 8 bits, polarity 1, phase 1, divider 3
    doXfer(16'hA303, 16'h12F0, 16'hBEEF, 0);
    // 15 bits, polarity 1, phase 0, divider 5
    doXfer(16'hBE05, 16'hD00D, 16'h4321, 0);
    // 11 bits, polarity 0, phase 1, float idle, divider 2, stray start
    doXfer(16'hED02, 16'h0555, 16'h06A9, 1);
    chk(dataOutEn == 1'b0, "R9 float while idle", dataOutEn, 0);
    // 16 bits, slowest divider
    doXfer(16'h80FF, 16'hFFFF, 16'h0001, 0);
    // 9 bits, polarity 1, phase 1, divider 2
    doXfer(16'hA702, 16'h01AB, 16'h0155, 0);

    tryBad(16'h0002, "enable clear");
    tryBad(16'h8000, "divider 0");
    tryBad(16'h8001, "divider 1");
    tryBad(16'h8C02, "reserved size");

    @(negedge clk);
    modeReg = 16'h8202;
    @(negedge clk);
    chk(serClk == 1'b1, "R3 idle high with polarity 1", serClk, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule